// File: doc/BRIEF.md
# Three-Step Register Exchange Controller

This block trades the contents of two data registers, X and Y, over one internal transfer bus. A third register, T, holds a value for the one cycle in which it would otherwise be lost. Software or a neighbouring block first loads X and Y through a parallel load path. It then raises `start`, and a three-state Mealy controller drives the output-enable and capture-enable lines of the three registers.

The bus is a multiplexer selected by the one-hot output enables, and it reads zero when no enable is active. The controller's outputs depend on both its state and `start`. For that reason the first transfer (Y onto the bus, captured by T) is issued in the same cycle in which `start` is seen. The exchange therefore finishes in three cycles with only three states.

A `done` pulse marks the final cycle. A new exchange may begin in the cycle right after `done`.

Top module: `regswap_unit`

## Requirements
- R1: While `rst_n` is low, the controller is forced idle and X, Y and T clear to zero. With `start` low after release, `done` is 0 and `xfer_bus` is 0.
- R2: In the idle state with `start` low and no load enable high, no register changes, `done` stays 0, and the controller stays idle.
- R3: In the idle state with `start` high, `xfer_bus` carries Y in that same cycle. T captures it at the next rising edge, and the controller moves to its second step.
- R4: In the second step, `xfer_bus` carries X and Y captures it at the next edge. `start` is ignored in this step.
- R5: In the third step, `xfer_bus` carries T and X captures it at the next edge. `done` is 1 in this cycle only, and the controller returns to idle.
- R6: One exchange takes exactly three cycles. Afterwards X holds the former Y, Y holds the former X, and T holds the former Y. Holding `start` high makes a new exchange begin in the cycle right after `done`, so two exchanges in a row restore the original values.
- R7: At most one register drives the bus in any cycle. When none drives it, `xfer_bus` is all zeros.
- R8: A register changes only at a rising edge in which its capture enable is high, or, for X and Y only, an accepted load. Load requests during the second and third steps have no effect.
- R9: In the idle state with `start` low, `ld_x_we` writes `ld_x_val` into X and `ld_y_we` writes `ld_y_val` into Y at the next edge, independently of each other. If `start` is high in the same cycle, the exchange wins and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an exchange when seen in the idle state |
| ld_x_we | input | 1 | Load request for X |
| ld_x_val | input | DATA_W | Value to load into X |
| ld_y_we | input | 1 | Load request for Y |
| ld_y_val | input | DATA_W | Value to load into Y |
| val_x | output | DATA_W | Current content of X |
| val_y | output | DATA_W | Current content of Y |
| val_t | output | DATA_W | Current content of the holding register T |
| xfer_bus | output | DATA_W | Value on the shared transfer bus |
| done | output | 1 | High during the final step of an exchange |

## Verification
A controller stuck in the wrong state shows at the ports within one cycle. Either `xfer_bus` carries the wrong register, or it reads zero where a transfer was due. `done` also appears early, late or not at all. A wrong capture enable corrupts a register value that is visible at the next edge. The bench therefore compares the bus, `done` and all three register outputs every cycle against a cycle-accurate reference model. It also drives load requests while the controller is busy and while `start` is high, so that a dropped priority shows up as a changed X or Y.

// File: rtl/regswap_pkg.sv
package regswap_pkg;

   // Register indices. The load path and the bus rely on this order.
   localparam int SEL_X = 0;
   localparam int SEL_Y = 1;
   localparam int SEL_T = 2;
   localparam int NREG  = 3;
   localparam int NLOAD = 2;

   // Two-bit state; idle is all zeros.
   typedef enum logic [1:0] {
      ST_IDLE   = 2'b00,
      ST_MOVE_X = 2'b01,
      ST_PUT_T  = 2'b10
   } swap_state_e;

   typedef struct packed {
      logic [NREG-1:0] oe;
      logic [NREG-1:0] ie;
      logic            done;
   } swap_ctl_t;

endpackage

// File: rtl/regswap_fsm.sv
module regswap_fsm
   import regswap_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   output swap_state_e state_q,
   output swap_ctl_t   ctl,
   output logic        ld_ok
);

   swap_state_e state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // Mealy decode: the first transfer depends on start directly.
   always_comb begin
      ctl     = '0;
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               ctl.oe[SEL_Y] = 1'b1;
               ctl.ie[SEL_T] = 1'b1;
               state_d       = ST_MOVE_X;
            end
         end
         ST_MOVE_X: begin
            ctl.oe[SEL_X] = 1'b1;
            ctl.ie[SEL_Y] = 1'b1;
            state_d       = ST_PUT_T;
         end
         ST_PUT_T: begin
            ctl.oe[SEL_T] = 1'b1;
            ctl.ie[SEL_X] = 1'b1;
            ctl.done      = 1'b1;
            state_d       = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // Loads accepted only when idle and no exchange is starting.
   assign ld_ok = (state_q == ST_IDLE) && !start;

endmodule

// File: rtl/regswap_bus.sv
module regswap_bus #(
   parameter int W         = 8,
   parameter int N         = 3,
   parameter int BUS_STYLE = 0   // 0: and-or mux, 1: priority chain
) (
   input  logic [N-1:0][W-1:0] regs,
   input  logic [N-1:0]        oe,
   output logic [W-1:0]        bus
);

   generate
      if (BUS_STYLE == 0) begin : g_andor
         always_comb begin
            bus = '0;
            for (int i = 0; i < N; i++) begin
               bus = bus | (regs[i] & {W{oe[i]}});
            end
         end
      end else begin : g_prio
         always_comb begin
            bus = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (oe[i]) bus = regs[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/regswap_regfile.sv
module regswap_regfile #(
   parameter int W     = 8,
   parameter int N     = 3,
   parameter int NLOAD = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [W-1:0]            bus,
   input  logic [N-1:0]            ie,
   input  logic                    ld_ok,
   input  logic [NLOAD-1:0]        ld_we,
   input  logic [NLOAD-1:0][W-1:0] ld_val,
   output logic [N-1:0][W-1:0]     regs
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_reg
         if (i < NLOAD) begin : g_loadable
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                   regs[i] <= '0;
               else if (ie[i])               regs[i] <= bus;
               else if (ld_ok && ld_we[i])   regs[i] <= ld_val[i];
            end
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)     regs[i] <= '0;
               else if (ie[i]) regs[i] <= bus;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/regswap_unit.sv
module regswap_unit
   import regswap_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int BUS_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ld_x_we,
   input  logic [DATA_W-1:0] ld_x_val,
   input  logic              ld_y_we,
   input  logic [DATA_W-1:0] ld_y_val,
   output logic [DATA_W-1:0] val_x,
   output logic [DATA_W-1:0] val_y,
   output logic [DATA_W-1:0] val_t,
   output logic [DATA_W-1:0] xfer_bus,
   output logic              done
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("regswap_unit: DATA_W must be at least 1");
      end
      if (BUS_STYLE != 0 && BUS_STYLE != 1) begin : g_bad_style
         $error("regswap_unit: BUS_STYLE must be 0 or 1");
      end
   endgenerate

   swap_state_e                  cur_state;
   swap_ctl_t                    ctl;
   logic                         ld_ok;
   logic [NREG-1:0]              oe_vec;
   logic [NREG-1:0]              ie_vec;
   logic [NREG-1:0][DATA_W-1:0]  regs;
   logic [NLOAD-1:0]             ld_we;
   logic [NLOAD-1:0][DATA_W-1:0] ld_val;

   regswap_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .state_q (cur_state),
      .ctl     (ctl),
      .ld_ok   (ld_ok)
   );

   assign oe_vec = ctl.oe;
   assign ie_vec = ctl.ie;
   assign done   = ctl.done;

   assign ld_we[SEL_X]  = ld_x_we;
   assign ld_we[SEL_Y]  = ld_y_we;
   assign ld_val[SEL_X] = ld_x_val;
   assign ld_val[SEL_Y] = ld_y_val;

   regswap_bus #(
      .W         (DATA_W),
      .N         (NREG),
      .BUS_STYLE (BUS_STYLE)
   ) u_bus (
      .regs (regs),
      .oe   (oe_vec),
      .bus  (xfer_bus)
   );

   regswap_regfile #(
      .W     (DATA_W),
      .N     (NREG),
      .NLOAD (NLOAD)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .bus    (xfer_bus),
      .ie     (ie_vec),
      .ld_ok  (ld_ok),
      .ld_we  (ld_we),
      .ld_val (ld_val),
      .regs   (regs)
   );

   assign val_x = regs[SEL_X];
   assign val_y = regs[SEL_Y];
   assign val_t = regs[SEL_T];

endmodule

// File: rtl/regswap_checker.sv
module regswap_checker
   import regswap_pkg::*;
#(
   parameter int W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [1:0]      state,
   input logic [NREG-1:0] oe,
   input logic [NREG-1:0] ie,
   input logic            done,
   input logic            ld_x_we,
   input logic [W-1:0]    ld_x_val,
   input logic [W-1:0]    val_x,
   input logic [W-1:0]    val_y,
   input logic [W-1:0]    val_t,
   input logic [W-1:0]    xfer_bus
);

   logic idle;
   assign idle = (state == ST_IDLE);

   AST_OE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(oe)); // R7
   AST_BUS_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (oe == '0) |-> (xfer_bus == '0)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !start) |-> (oe == '0 && ie == '0 && !done)); // R2
   AST_START_TAKES_Y: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start) |=> (val_t == $past(val_y) && state == ST_MOVE_X)); // R3
   AST_Y_TAKES_X: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MOVE_X) |=> (val_y == $past(val_x) && state == ST_PUT_T)); // R4
   AST_X_TAKES_T: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (val_x == $past(val_t))); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && state == ST_IDLE)); // R5
   AST_T_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ie[SEL_T] |=> $stable(val_t)); // R8
   AST_LOAD_X: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !start && ld_x_we) |=> (val_x == $past(ld_x_val))); // R9

endmodule

bind regswap_unit regswap_checker #(.W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .state    (cur_state),
   .oe       (oe_vec),
   .ie       (ie_vec),
   .done     (done),
   .ld_x_we  (ld_x_we),
   .ld_x_val (ld_x_val),
   .val_x    (val_x),
   .val_y    (val_y),
   .val_t    (val_t),
   .xfer_bus (xfer_bus)
);

// File: tb/regswap_unit_bench.sv
`timescale 1ns/1ps
module regswap_unit_bench;

   localparam int W = 8;

   typedef struct {
      logic         done;
      logic [W-1:0] bus;
      logic [W-1:0] x;
      logic [W-1:0] y;
      logic [W-1:0] t;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         ld_x_we = 1'b0;
   logic [W-1:0] ld_x_val = '0;
   logic         ld_y_we = 1'b0;
   logic [W-1:0] ld_y_val = '0;
   logic [W-1:0] val_x, val_y, val_t, xfer_bus;
   logic         done;

   int n_cmp = 0;
   int n_bad = 0;
   int done_seen = 0;
   int done_exp = 0;
   bit summary_done = 0;
   exp_t q[$];

   // Reference model state: 0 idle, 1 second step, 2 third step.
   int           ms = 0;
   logic [W-1:0] mx = '0, my = '0, mt = '0;

   always #10 clk = ~clk;

   regswap_unit #(.DATA_W(W)) u_regswap_unit (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ld_x_we(ld_x_we), .ld_x_val(ld_x_val),
      .ld_y_we(ld_y_we), .ld_y_val(ld_y_val),
      .val_x(val_x), .val_y(val_y), .val_t(val_t),
      .xfer_bus(xfer_bus), .done(done)
   );

   task automatic step(input logic s, input logic lxw, input logic [W-1:0] lxv,
                       input logic lyw, input logic [W-1:0] lyv, input string tag_in);
      exp_t e;
      @(negedge clk);
      start = s; ld_x_we = lxw; ld_x_val = lxv; ld_y_we = lyw; ld_y_val = lyv;
      e.x = mx; e.y = my; e.t = mt;
      e.done = (ms == 2);
      e.bus = (ms == 0) ? (s ? my : '0) : (ms == 1) ? mx : mt;
      if (tag_in != "") e.tag = tag_in;
      else if (ms == 0) e.tag = s ? "R3" : ((lxw || lyw) ? "R9" : "R2");
      else e.tag = (ms == 1) ? "R4" : "R5";
      q.push_back(e);
      if (e.done) done_exp++;
      case (ms)
         0: if (s) begin mt = my; ms = 1; end
            else begin
               if (lxw) mx = lxv;
               if (lyw) my = lyv;
            end
         1: begin my = mx; ms = 2; end
         default: begin mx = mt; ms = 0; end
      endcase
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0, '0, "");
   endtask

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected item per cycle and compares every output.
   initial begin
      forever begin
         @(negedge clk);
         #4;
         if (done === 1'b1) done_seen++;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (done !== e.done || xfer_bus !== e.bus || val_x !== e.x ||
                val_y !== e.y || val_t !== e.t) begin
               n_bad++;
               $display("FAIL %s: actual done=%b bus=%h x=%h y=%h t=%h expected done=%b bus=%h x=%h y=%h t=%h",
                        e.tag, done, xfer_bus, val_x, val_y, val_t,
                        e.done, e.bus, e.x, e.y, e.t);
            end
         end
      end
   end

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      // R1: reset clears everything; checked on the first idle cycle.
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, '0, 1'b0, '0, "R1");
      quiet(2);                                     // R2 / R7: bus zero when idle

      // R9: independent loads
      step(1'b0, 1'b1, 8'h3C, 1'b0, 8'hFF, "");
      step(1'b0, 1'b0, 8'h00, 1'b1, 8'hA5, "");
      quiet(1);

      // R3, R4, R5: one exchange; R8: loads while busy are dropped
      step(1'b1, 1'b0, '0, 1'b0, '0, "");
      step(1'b1, 1'b1, 8'h11, 1'b1, 8'h22, "R8");
      step(1'b0, 1'b1, 8'h33, 1'b1, 8'h44, "R8");
      quiet(2);
      chk("R6", val_x, 8'hA5);
      chk("R6", val_y, 8'h3C);
      chk("R6", val_t, 8'hA5);
      chk("R7", xfer_bus, 8'h00);

      // R6: back-to-back exchanges with start held high
      step(1'b0, 1'b1, 8'h5A, 1'b1, 8'hC3, "R9");
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, '0, 1'b0, '0, "R6");
      quiet(2);
      chk("R6", val_x, 8'h5A);
      chk("R6", val_y, 8'hC3);

      // R9: load in the same cycle as start is dropped
      step(1'b1, 1'b1, 8'h01, 1'b1, 8'h02, "R9");
      quiet(3);
      chk("R9", val_x, 8'hC3);
      chk("R9", val_y, 8'h5A);

      // R2: idle with start low leaves everything unchanged
      quiet(3);
      chk("R2", val_t, 8'hC3);

      // R5: done pulses, one per exchange
      n_cmp++;
      if (done_seen != done_exp) begin
         n_bad++;
         $display("FAIL R5: actual %0d done cycles expected %0d", done_seen, done_exp);
      end
      finish_run();
   end

endmodule